// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block resolves data hazards for a five-stage in-order pipeline (fetch, decode with register read, execute, memory, writeback). Each cycle it takes the decoded fields of the instruction in decode: source register numbers, per-operand use flags, destination, write enable and a load flag. It carries the destination tags of that instruction and the two instructions ahead of it through its own copies of the execute, memory and writeback slots.

For the instruction in execute, it drives one select per ALU operand. The select picks the register-file value, the result held at the end of the memory stage, or the result about to be written back. A dependency three instructions apart is left to the register file, which writes early in the cycle and reads late.

A load's data arrives too late for the very next instruction. When the instruction in decode reads the destination of a load sitting in execute, the block raises `stall` and `bubble` for one cycle. The datapath then holds the PC and the fetch/decode register and loads a no-op into execute, and the block itself records an empty slot there. Two cycles later the dependent instruction is in execute and takes the loaded value from the writeback side.

Top module: `fwd_interlock`

## Requirements
- R1: While reset is held and on the first cycle after it, with no valid instruction offered, both operand selects are 00 and `stall` and `bubble` are low.
- R2: The operand select is 2'b10 (take the result in the memory stage) when that instruction writes a nonzero register equal to the operand's source register and the operand is used.
- R3: The operand select is 2'b01 (take the writeback result) when the writeback-stage instruction writes a nonzero register equal to the used operand's source register and R2 does not apply; otherwise the select is 2'b00 (register file).
- R4: When both older instructions write the same register that an operand reads, the nearer one (memory stage, select 2'b10) wins.
- R5: A destination of register zero, or an older instruction whose write enable is low, never causes forwarding or a stall.
- R6: An operand whose use flag is low gets select 2'b00 and never causes a stall, even when its register number matches.
- R7: `stall` and `bubble` are high in the same cycle in which a valid instruction in decode uses the nonzero destination of a writing load in execute.
- R8: A stall lasts exactly one cycle for a held instruction. The cycle after it shows 2'b00 selects for the empty execute slot, and the dependent operand then gets select 2'b01 in the following cycle.
- R9: A dependency on a non-load instruction directly ahead, or an instruction after a load that does not read the load's destination, causes no stall.
- R10: An instruction offered with `id_valid` low enters execute as a no-op. It never forwards a result to later instructions and never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_src1 | input | RW | First source register number |
| id_src2 | input | RW | Second source register number |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| id_dst | input | RW | Destination register number |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| sel_a | output | 2 | First ALU operand select: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Second ALU operand select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble | output | 1 | Load a no-op into execute this cycle |

## Verification
The assertions assume that the decode inputs are stable for the whole cycle. They also assume the surrounding pipeline honours `stall` by offering the same instruction again on the next cycle, since the one-cycle stall property only holds if the held instruction is not replaced by another load consumer. The stimulus keeps to this: it changes decode inputs only on the falling edge and re-offers the held instruction whenever its own model predicts a stall. It draws register numbers from a small set, so matches, register-zero destinations, unused operands and back-to-back loads occur often.

// File: rtl/fwd_interlock.sv
module fwd_interlock #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [RW-1:0] id_src1,
  input  logic [RW-1:0] id_src2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [RW-1:0] id_dst,
  input  logic          id_wen,
  input  logic          id_load,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          stall,
  output logic          bubble
);

  localparam logic [RW-1:0] ZERO = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic [RW-1:0] ex_src1, ex_src2, ex_dst, mem_dst, wb_dst;
  logic          ex_use1, ex_use2, ex_wen, ex_load;
  logic          mem_wen, mem_load, wb_wen;

  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;
  logic ld_hit1, ld_hit2, ex_ld_live;
  logic take;

  assign ex_ld_live = ex_load & ex_wen & (ex_dst != ZERO);
  assign ld_hit1 = id_use1 & (id_src1 == ex_dst);
  assign ld_hit2 = id_use2 & (id_src2 == ex_dst);
  assign stall  = id_valid & ex_ld_live & (ld_hit1 | ld_hit2);
  assign bubble = stall;
  assign take   = id_valid & ~stall;

  always_ff @(posedge clk) begin
    if (!rst_n || !take) begin
      ex_src1 <= ZERO;
      ex_src2 <= ZERO;
      ex_dst  <= ZERO;
      ex_use1 <= 1'b0;
      ex_use2 <= 1'b0;
      ex_wen  <= 1'b0;
      ex_load <= 1'b0;
    end else begin
      ex_src1 <= id_src1;
      ex_src2 <= id_src2;
      ex_dst  <= id_dst;
      ex_use1 <= id_use1;
      ex_use2 <= id_use2;
      ex_wen  <= id_wen;
      ex_load <= id_load;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_dst  <= ZERO;
      mem_wen  <= 1'b0;
      mem_load <= 1'b0;
      wb_dst   <= ZERO;
      wb_wen   <= 1'b0;
    end else begin
      mem_dst  <= ex_dst;
      mem_wen  <= ex_wen;
      mem_load <= ex_load;
      wb_dst   <= mem_dst;
      wb_wen   <= mem_wen;
    end
  end

  assign mem_hit_a = ex_use1 & mem_wen & (mem_dst != ZERO) & (mem_dst == ex_src1);
  assign mem_hit_b = ex_use2 & mem_wen & (mem_dst != ZERO) & (mem_dst == ex_src2);
  assign wb_hit_a  = ex_use1 & wb_wen  & (wb_dst  != ZERO) & (wb_dst  == ex_src1);
  assign wb_hit_b  = ex_use2 & wb_wen  & (wb_dst  != ZERO) & (wb_dst  == ex_src2);

  assign sel_a = mem_hit_a ? SEL_MEM : (wb_hit_a ? SEL_WB : SEL_RF);
  assign sel_b = mem_hit_b ? SEL_MEM : (wb_hit_b ? SEL_WB : SEL_RF);

  p_fwd_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_MEM) |-> (mem_wen && mem_dst == ex_src1 && ex_use1));
  p_fwd_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == SEL_WB) |-> (wb_wen && wb_dst == ex_src2 && mem_dst != ex_src2 || !mem_wen && wb_dst == ex_src2));
  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_use1 && mem_wen && wb_wen && mem_dst == wb_dst && mem_dst == ex_src1 && ex_src1 != ZERO) |-> (sel_a == SEL_MEM));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != SEL_RF) |-> (ex_src1 != ZERO));
  p_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_use2) |-> (sel_b == SEL_RF));
  p_stall_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_load && ex_wen && bubble));
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!stall && sel_a == SEL_RF && sel_b == SEL_RF));
  p_no_late_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_MEM) |-> !mem_load);
  p_nonload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_load) |-> !stall);
  p_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid) |=> (!ex_wen && !ex_use1 && !ex_use2));

endmodule

// File: tb/sim_fwd_interlock.sv
module sim_fwd_interlock;
  localparam int RW = 5;
  localparam time TCLK = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic id_valid, id_use1, id_use2, id_wen, id_load;
  logic [RW-1:0] id_src1, id_src2, id_dst;
  logic [1:0] sel_a, sel_b;
  logic stall, bubble;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct {
    bit v; int s1; int s2; bit u1; bit u2; int d; bit w; bit l;
  } ins_t;

  ins_t pipe[$];
  ins_t cur;

  fwd_interlock #(.RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .id_src1(id_src1), .id_src2(id_src2), .id_use1(id_use1), .id_use2(id_use2),
    .id_dst(id_dst), .id_wen(id_wen), .id_load(id_load),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall), .bubble(bubble)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic ins_t nop();
    ins_t n;
    n = '{v:0, s1:0, s2:0, u1:0, u2:0, d:0, w:0, l:0};
    return n;
  endfunction

  function automatic int exp_sel(int src, bit used);
    if (!used || src == 0) return 0;
    if (pipe[1].w && pipe[1].d == src) return 2;
    if (pipe[2].w && pipe[2].d == src) return 1;
    return 0;
  endfunction

  function automatic bit exp_stall();
    ins_t e;
    e = pipe[0];
    if (!cur.v || !e.l || !e.w || e.d == 0) return 0;
    return (cur.u1 && cur.s1 == e.d) || (cur.u2 && cur.s2 == e.d);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one clock: drive cur, compare against model, advance model; returns predicted stall
  task automatic step(output bit st);
    int ea, eb;
    @(negedge clk);
    id_valid = cur.v; id_src1 = RW'(cur.s1); id_src2 = RW'(cur.s2);
    id_use1 = cur.u1; id_use2 = cur.u2; id_dst = RW'(cur.d);
    id_wen = cur.w; id_load = cur.l;
    #1;
    ea = exp_sel(pipe[0].s1, pipe[0].u1);
    eb = exp_sel(pipe[0].s2, pipe[0].u2);
    st = exp_stall();
    check("R2 R3 R4 R5 R6 sel_a", int'(sel_a), ea);
    check("R2 R3 R4 R5 R6 sel_b", int'(sel_b), eb);
    check("R7 R9 R10 stall", int'(stall), int'(st));
    check("R7 bubble", int'(bubble), int'(st));
    @(posedge clk);
    pipe.push_front((st || !cur.v) ? nop() : cur);
    void'(pipe.pop_back());
  endtask

  // issue one instruction, re-offering it while the model predicts a stall
  task automatic issue(bit v, int s1, bit u1, int s2, bit u2, int d, bit w, bit l);
    bit st;
    int n = 0;
    cur = '{v:v, s1:s1, s2:s2, u1:u1, u2:u2, d:d, w:w, l:l};
    do begin
      step(st);
      n++;
      if (n > 2) check("R8 stall length", n, 2);
    end while (st && n <= 2);
  endtask

  initial begin
    int t0;
    t0 = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    bit st;
    repeat (3) pipe.push_back(nop());
    cur = nop();
    rst_n = 1'b0;
    id_valid = 0; id_src1 = '0; id_src2 = '0; id_use1 = 0; id_use2 = 0;
    id_dst = '0; id_wen = 0; id_load = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 sel_a reset", int'(sel_a), 0);
    check("R1 sel_b reset", int'(sel_b), 0);
    check("R1 stall reset", int'(stall), 0);
    rst_n = 1'b1;
    step(st); // R1 first cycle after reset

    // R2: ALU result one ahead
    issue(1, 0,0, 0,0, 3,1,0);
    issue(1, 3,1, 4,1, 5,1,0);
    issue(1, 0,0, 0,0, 0,0,0);
    // R3: two ahead
    issue(1, 0,0, 0,0, 6,1,0);
    issue(1, 0,0, 0,0, 0,0,0);
    issue(1, 1,1, 6,1, 7,1,0);
    // R4: both ahead write the same register
    issue(1, 0,0, 0,0, 2,1,0);
    issue(1, 0,0, 0,0, 2,1,0);
    issue(1, 2,1, 2,1, 8,1,0);
    // R5: register zero and no-write producers
    issue(1, 0,0, 0,0, 0,1,1);
    issue(1, 0,1, 0,1, 9,0,1);
    issue(1, 9,1, 0,1, 1,1,0);
    // R6: unused operand matches a load destination
    issue(1, 0,0, 0,0, 4,1,1);
    issue(1, 4,0, 4,0, 10,1,0);
    // R7 R8: load-use on operand B, then forwarded from writeback
    issue(1, 0,0, 0,0, 11,1,1);
    issue(1, 1,1, 11,1, 12,1,0);
    issue(1, 12,1, 0,0, 13,1,0);
    // R9: unrelated instruction after a load, then its consumer
    issue(1, 0,0, 0,0, 14,1,1);
    issue(1, 15,1, 16,1, 17,1,0);
    issue(1, 14,1, 0,0, 18,1,0);
    // R10: invalid slot carrying a load
    issue(0, 0,0, 0,0, 19,1,1);
    issue(1, 19,1, 19,1, 20,1,0);
    // back-to-back loads with chained use
    issue(1, 0,0, 0,0, 21,1,1);
    issue(1, 21,1, 0,0, 22,1,1);
    issue(1, 22,1, 22,1, 23,1,0);

    // pseudo-random mix over a small register set
    for (int i = 0; i < 3000; i++) begin
      issue(($urandom % 8) != 0, $urandom % 4, $urandom % 2, $urandom % 4,
            $urandom % 2, $urandom % 4, $urandom % 4 != 0, $urandom % 3 == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule